// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table held in memory, with 4 KB pages. A translation request arrives on a valid/ready channel. The walker slices the address into a 10-bit upper index, a 10-bit lower index and a 12-bit byte offset. It first reads the upper-level entry, found through a programmable table-base register. That entry names the page holding a lower-level table. The walker then reads the lower-level entry, which names the physical frame. The frame number and the untouched offset form the physical address. If either entry is not marked valid, the walk stops and the block reports which level failed.

Every table entry is a 32-bit word. Bits [31:12] hold a 4 KB-aligned page number, either the next table or the frame. Bit 0 is the valid flag. Bits [11:1] carry no meaning. An entry's byte address is the table page number followed by the index and two zero bits.

Memory is reached through a single-outstanding read port. The request side is valid/ready: the address is held until the memory accepts it. The response side is a one-cycle valid pulse with no back-pressure. The result side is also valid/ready: a result waits, unchanged, for as long as the consumer holds `res_ready` low. The request channel stalls (`req_ready` low) for the whole walk, including while a result waits to be taken.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only when no walk is in progress and no result is waiting. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The values of `req_vaddr` and `req_valid` on any other edge have no effect.
- R2: The cycle after a request is accepted, the walker asks for the upper-level entry at `{base[31:12], va[31:22], 2'b00}`. Here `base` is the table-base register value in the accept cycle.
- R3: After an upper-level response with bit 0 = 1, the next memory request is for the lower-level entry at `{upper[31:12], va[21:12], 2'b00}`.
- R4: An upper-level response with bit 0 = 0 ends the walk with `res_fault`=1 and `res_level`=0 (upper). No lower-level read is made. `res_vaddr` carries the faulting address.
- R5: A lower-level response with bit 0 = 0 ends the walk with `res_fault`=1 and `res_level`=1 (lower). `res_vaddr` carries the faulting address.
- R6: A lower-level response with bit 0 = 1 ends the walk with `res_fault`=0 and `res_paddr` = `{lower[31:12], va[11:0]}`. Entry bits [11:1] have no effect at either level.
- R7: A memory request stays valid with a stable address until `mem_req_ready` is seen. Only one read is outstanding at a time. A walk makes exactly one read per level it reaches.
- R8: A `mem_rsp_valid` pulse while no read is outstanding has no effect.
- R9: `res_valid` rises in the cycle after the final memory response. The result holds stable until it is taken with `res_ready`. `req_ready` is high in the cycle after that handshake.
- R10: A `base_wr` pulse loads `base_data[31:12]` into the table-base register, and `base_data[11:0]` is ignored. The new base applies to requests accepted on later edges. A request accepted on the same edge as the write still uses the old base.
- R11: After reset, `req_ready`=1, `res_valid`=0, `mem_req_valid`=0, and the table base is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr | input | 1 | Load the table-base register |
| base_data | input | 32 | New table base; bits [31:12] used |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data present (one-cycle pulse) |
| mem_rsp_data | input | 32 | Table entry read |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_fault | output | 1 | Walk ended on an invalid entry |
| res_level | output | 1 | Failing level: 0 upper, 1 lower |
| res_paddr | output | 32 | Physical address (when no fault) |
| res_vaddr | output | 32 | Virtual address of this walk |

## Verification
Timing is fixed in each case:
- The upper-level read request is due one cycle after acceptance.
- The lower-level request is due one cycle after a valid upper response.
- The result is due one cycle after the last response.
- `req_ready` returns one cycle after the result is taken.

The bench runs a behavioural model, updated on each rising edge from the handshakes it sees. At every falling edge it compares `req_ready`, `res_valid` and `mem_req_valid` with what the model expects for that cycle. Read addresses are checked at each memory handshake, and result fields are checked at each result handshake. Memory accept, response latency, consumer readiness and stray response pulses are all randomised. This makes each of these due-cycle rules hold under stall.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OUTER,
    ST_RD_INNER,
    ST_DONE,
    ST_FAULT
  } walk_st_e;

  localparam logic LVL_OUTER = 1'b0;
  localparam logic LVL_INNER = 1'b1;

endpackage

// File: rtl/walk_ent_addr.sv
// Forms the byte address of a table entry from a table page number and an index.
module walk_ent_addr #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-OFF_W-1:0] tbl_page,
  input  logic [IDX_W-1:0]        idx,
  output logic [ADDR_W-1:0]       ent_addr
);
  localparam int PAD_W = OFF_W - IDX_W;

  assign ent_addr = {tbl_page, idx, {PAD_W{1'b0}}};
endmodule

// File: rtl/walk_ctrl.sv
// Sequencer: accepts a request, issues one read per level, decides the outcome.
module walk_ctrl
  import walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] outer_addr,
  input  logic [ADDR_W-1:0] inner_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic              rsp_ok,
  input  logic              res_ready,
  output walk_st_e          st,
  output logic [ADDR_W-1:0] va_q,
  output logic              cap_ok,
  output logic              cap_flt,
  output logic              cap_lvl
);
  logic              issued;
  logic [ADDR_W-1:0] rd_addr;
  logic              reading;
  logic              rsp_hit;

  assign reading = (st == ST_RD_OUTER) || (st == ST_RD_INNER);
  assign rsp_hit = reading && issued && mem_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      issued  <= 1'b0;
      va_q    <= '0;
      rd_addr <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            va_q    <= req_vaddr;
            rd_addr <= outer_addr;
            issued  <= 1'b0;
            st      <= ST_RD_OUTER;
          end
        end
        ST_RD_OUTER, ST_RD_INNER: begin
          if (!issued) begin
            if (mem_req_ready) issued <= 1'b1;
          end else if (mem_rsp_valid) begin
            issued <= 1'b0;
            if (!rsp_ok) begin
              st <= ST_FAULT;
            end else if (st == ST_RD_OUTER) begin
              rd_addr <= inner_addr;
              st      <= ST_RD_INNER;
            end else begin
              st <= ST_DONE;
            end
          end
        end
        ST_DONE, ST_FAULT: begin
          if (res_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = reading && !issued;
  assign mem_req_addr  = rd_addr;
  assign cap_ok        = rsp_hit && rsp_ok && (st == ST_RD_INNER);
  assign cap_flt       = rsp_hit && !rsp_ok;
  assign cap_lvl       = (st == ST_RD_INNER) ? LVL_INNER : LVL_OUTER;
endmodule

// File: rtl/walk_result.sv
// Holds the captured frame or fault level and assembles the result fields.
module walk_result
  import walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walk_st_e          st,
  input  logic [ADDR_W-1:0] va_q,
  input  logic              cap_ok,
  input  logic              cap_flt,
  input  logic              cap_lvl,
  input  logic [ADDR_W-OFF_W-1:0] rsp_page,
  output logic              res_valid,
  output logic              res_fault,
  output logic              res_level,
  output logic [ADDR_W-1:0] res_paddr,
  output logic [ADDR_W-1:0] res_vaddr
);
  logic [ADDR_W-OFF_W-1:0] frame_q;
  logic                    lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      lvl_q   <= LVL_OUTER;
    end else begin
      if (cap_ok)  frame_q <= rsp_page;
      if (cap_flt) lvl_q   <= cap_lvl;
    end
  end

  assign res_valid = (st == ST_DONE) || (st == ST_FAULT);
  assign res_fault = (st == ST_FAULT);
  assign res_level = lvl_q;
  assign res_paddr = {frame_q, va_q[OFF_W-1:0]};
  assign res_vaddr = va_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_fault,
  output logic              res_level,
  output logic [ADDR_W-1:0] res_paddr,
  output logic [ADDR_W-1:0] res_vaddr
);
  localparam int PG_W    = ADDR_W - OFF_W;
  localparam int HI_LSB  = OFF_W + IDX_W;

  logic [PG_W-1:0]   base_pg_q;
  logic [ADDR_W-1:0] outer_addr;
  logic [ADDR_W-1:0] inner_addr;
  logic [ADDR_W-1:0] va_q;
  walk_st_e          st;
  logic              cap_ok;
  logic              cap_flt;
  logic              cap_lvl;
  logic              unused_bits;

  assign unused_bits = ^{base_data[OFF_W-1:0], mem_rsp_data[OFF_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_pg_q <= '0;
    else if (base_wr) base_pg_q <= base_data[ADDR_W-1:OFF_W];
  end

  walk_ent_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_outer_addr (
    .tbl_page (base_pg_q),
    .idx      (req_vaddr[HI_LSB +: IDX_W]),
    .ent_addr (outer_addr)
  );

  walk_ent_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_inner_addr (
    .tbl_page (mem_rsp_data[ADDR_W-1:OFF_W]),
    .idx      (va_q[OFF_W +: IDX_W]),
    .ent_addr (inner_addr)
  );

  walk_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_ready     (req_ready),
    .outer_addr    (outer_addr),
    .inner_addr    (inner_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_ok        (mem_rsp_data[0]),
    .res_ready     (res_ready),
    .st            (st),
    .va_q          (va_q),
    .cap_ok        (cap_ok),
    .cap_flt       (cap_flt),
    .cap_lvl       (cap_lvl)
  );

  walk_result #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .va_q      (va_q),
    .cap_ok    (cap_ok),
    .cap_flt   (cap_flt),
    .cap_lvl   (cap_lvl),
    .rsp_page  (mem_rsp_data[ADDR_W-1:OFF_W]),
    .res_valid (res_valid),
    .res_fault (res_fault),
    .res_level (res_level),
    .res_paddr (res_paddr),
    .res_vaddr (res_vaddr)
  );
endmodule

// File: rtl/walk_chk.sv
module walk_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_fault,
  input logic              res_level,
  input logic [ADDR_W-1:0] res_paddr,
  input logic [ADDR_W-1:0] res_vaddr
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !res_valid && !mem_req_valid); // R1

  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R1

  AST_OUTER_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_req_valid &&
      mem_req_addr[OFF_W-1:OFF_W-IDX_W] == $past(req_vaddr[ADDR_W-1:ADDR_W-IDX_W])); // R2

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R7

  AST_NO_READ_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !mem_req_valid); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid &&
      $stable({res_fault, res_level, res_paddr, res_vaddr})); // R9

  AST_RESULT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> req_ready && !res_valid); // R9
endmodule

bind pt_walker walk_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_walk_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_vaddr     (req_vaddr),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_fault     (res_fault),
  .res_level     (res_level),
  .res_paddr     (res_paddr),
  .res_vaddr     (res_vaddr)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_wr = 1'b0;
  logic [31:0] base_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_fault;
  logic        res_level;
  logic [31:0] res_paddr;
  logic [31:0] res_vaddr;

  always #4 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_data(base_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_fault(res_fault),
    .res_level(res_level), .res_paddr(res_paddr), .res_vaddr(res_vaddr)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit [31:0] tbl [bit [31:0]];

  function automatic bit [31:0] rd_tbl(bit [31:0] a);
    if (tbl.exists(a)) return tbl[a];
    return 32'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit        m_busy, m_out, m_done;
  int        m_n, e_n;
  bit [31:0] m_base;
  bit [31:0] e_addr [2];
  bit [31:0] e_va, e_pa;
  bit        e_flt, e_lvl;
  int        walks = 0;

  task automatic predict(bit [31:0] va, bit [31:0] b);
    bit [31:0] o, i;
    e_va = va;
    e_addr[0] = {b[31:12], va[31:22], 2'b00};
    o = rd_tbl(e_addr[0]);
    e_pa = '0; e_lvl = 1'b0; e_flt = 1'b0;
    if (!o[0]) begin
      e_flt = 1'b1; e_lvl = 1'b0; e_n = 1;
    end else begin
      e_addr[1] = {o[31:12], va[21:12], 2'b00};
      i = rd_tbl(e_addr[1]);
      e_n = 2;
      if (!i[0]) begin
        e_flt = 1'b1; e_lvl = 1'b1;
      end else begin
        e_pa = {i[31:12], va[11:0]};
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_out = 0; m_done = 0; m_n = 0; e_n = 0; m_base = '0;
    end else begin
      if (req_valid && !m_busy) begin
        m_busy = 1; m_out = 0; m_done = 0; m_n = 0;
        predict(req_vaddr, m_base);
      end else if (res_valid && res_ready && m_done) begin
        walks++;
        chk("R4 vaddr", res_vaddr, e_va);
        if (e_flt) begin
          chk(e_lvl ? "R5 fault/level" : "R4 fault/level",
              {30'b0, res_fault, res_level}, {30'b0, 1'b1, e_lvl});
        end else begin
          chk("R6 fault flag", {31'b0, res_fault}, 32'h0);
          chk("R6 paddr", res_paddr, e_pa);
        end
        m_busy = 0; m_done = 0;
      end
      if (mem_rsp_valid && m_out) begin
        m_out = 0;
        if (m_n == e_n) m_done = 1;
      end
      if (mem_req_valid && mem_req_ready) begin
        if (m_n >= e_n || !m_busy) chk("R7 extra read", 32'h1, 32'h0);
        else chk(m_n == 0 ? "R2 upper addr" : "R3 lower addr", mem_req_addr, e_addr[m_n]);
        m_n++;
        m_out = 1;
      end
      if (base_wr) m_base = {base_data[31:12], 12'h0};  // R10
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 req_ready", {31'b0, req_ready}, {31'b0, !m_busy});
      chk("R9 res_valid", {31'b0, res_valid}, {31'b0, m_done});
      chk("R7 mem_req_valid", {31'b0, mem_req_valid},
          {31'b0, m_busy && !m_out && !m_done && (m_n < e_n)});
    end
  end

  // ---------------- memory responder (R8 strays) ----------------
  bit        r_pend = 0;
  bit [31:0] r_addr;
  int        r_cnt;

  always @(posedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      r_pend = 1; r_addr = mem_req_addr; r_cnt = $urandom % 4;
    end
  end

  always @(negedge clk) begin
    mem_rsp_valid <= 1'b0;
    mem_rsp_data  <= $urandom;
    mem_req_ready <= ($urandom % 5) < 3;
    res_ready     <= ($urandom % 4) != 0;
    if (r_pend) begin
      if (r_cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= rd_tbl(r_addr);
        r_pend = 0;
      end else r_cnt--;
    end else if (rst_n && ($urandom % 8) == 0) begin
      mem_rsp_valid <= 1'b1;  // R8 stray pulse, no read outstanding
    end
  end

  function automatic bit [31:0] pick();
    int unsigned his [6] = '{0, 1, 3, 5, 1023, 2};
    int unsigned los [6] = '{0, 7, 1023, 3, 2, 5};
    bit [9:0] h, l;
    h = 10'(his[$urandom % 6]);
    l = 10'(los[$urandom % 6]);
    return {h, l, 12'($urandom)};
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    tbl[32'h0000_000C] = 32'h0000_5001;
    tbl[32'h0000_501C] = 32'h00AA_A001;
    tbl[32'h0040_0000] = 32'h0000_2001;
    tbl[32'h0040_0004] = 32'h0081_3001;
    tbl[32'h0040_0014] = 32'h00AB_C000;
    tbl[32'h0040_0FFC] = 32'h0123_4FFF;
    tbl[32'h0081_3000] = 32'hCAFE_B001;
    tbl[32'h0081_301C] = 32'hDEAD_0000;
    tbl[32'h0081_3FFC] = 32'h1234_5FFF;
    tbl[32'h0000_200C] = 32'h0000_1001;
    tbl[32'h0123_4008] = 32'hFFFF_F003;
    tbl[32'h0070_0004] = 32'h0000_2001;
    tbl[32'h0070_000C] = 32'h0081_3FFF;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset req_ready", {31'b0, req_ready}, 32'h1);
    chk("R11 reset res_valid", {31'b0, res_valid}, 32'h0);
    chk("R11 reset mem_req_valid", {31'b0, mem_req_valid}, 32'h0);
    rst_n = 1'b1;

    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (k == 20)  begin base_wr = 1'b1; base_data = 32'h0040_0ABC; end  // R10 low bits ignored
      if (k == 300) begin base_wr = 1'b1; base_data = 32'h0070_0000; end
      req_valid = 1'b1;
      req_vaddr = pick();
      @(posedge clk);
      while (!req_ready) begin
        @(negedge clk);
        base_wr = 1'b0;
        req_vaddr = pick();  // R1 changes while stalled have no effect
        @(posedge clk);
      end
      @(negedge clk);
      base_wr = 1'b0;
      req_valid = ($urandom % 3) == 0;
      req_vaddr = pick();
    end
    @(negedge clk);
    req_valid = 1'b0;
    for (int w = 0; w < 100 && m_busy; w++) @(negedge clk);
    chk("R9 all walks retired", {31'b0, m_busy}, 32'h0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule